// File: doc/BRIEF.md
# Directory-Based Coherence, Lock and Notify Controller

This block is the directory engine that sits beside the storage array of a shared memory module. For every 128-byte block of that memory it holds one 16-bit state word. The word combines a presence mask of the requester ports, a lock flag and a two-bit mode code. Each bus operation arriving from a requester names a port, an opcode and a block index. The engine reads the block's word, decides whether the operation succeeds, is aborted or fails, computes which other ports must be interrupted, and writes the updated word back. The data movement itself is not modelled here. An ok outcome stands for "data accepted or returned".

The same word serves three purposes. It drives invalidation-based coherence with one writer or many readers. It drives memory-held locks that notify waiting ports on release. It drives a mailbox mode, in which a write to a block raises an interrupt at every port that registered interest, and the lock flag then means "written, not yet read". Software can also read and overwrite a word directly through two dedicated opcodes.

Operations are taken one at a time through a valid/ready pair. After reset, the engine first sweeps the whole directory to zero. It then accepts one operation every two cycles, so an operation always sees the word left by the previous one.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, op_ready stays low for exactly DEPTH cycles while every entry is cleared. Afterwards, any entry read back (opcode 12) is 16'h0000, even one written before the reset.
- R2: An operation is accepted in a cycle with op_valid and op_ready high. op_ready is low in the next cycle. rsp_valid is high for exactly one cycle, the second cycle after acceptance. A following operation on the same index sees the updated entry.
- R3: The entry layout is [15:14] mode code (01 shared, 10 private, 11 notify, 00 undefined), [13] lock flag, [12:0] presence bit per port. A block with no presence bit set is uncached. Read-shared (opcode 0) from port i on an uncached or shared block gives ok, sets bit i and sets the code to 01. Read-private (opcode 1) on an uncached block gives ok, sets the presence to only bit i and sets the code to 10.
- R4: Read-private (opcode 1) or assert-ownership (opcode 2) from port i on a shared block gives ok. The code becomes 10 and the presence becomes only bit i. rsp_irq holds every other port whose bit was set.
- R5: On a private block owned by another port, reads (opcodes 0, 1, 8, 9), assert-ownership (2), lock (5) and notify (7) are aborted, rsp_irq holds the owner and the entry is unchanged. A read from the owner itself gives ok and leaves the entry unchanged.
- R6: A writeback by the private owner gives ok and sets the code to 01. Opcodes 3 and 10 keep the owner's bit. Opcodes 4 and 11 clear it. A writeback from any port that is not the private owner fails and leaves the entry unchanged.
- R7: Lock (opcode 5) from port i gives ok and sets the lock flag when the flag is clear. It fails when the flag is set. In both cases bit i is set, and an uncached block takes code 01.
- R8: Unlock (opcode 6) from port i gives ok, clears the lock flag, and sets rsp_irq to every other port whose bit is set. The unlocking writebacks (opcodes 10 and 11) by the owner also clear the flag.
- R9: The locking reads (opcodes 8 shared and 9 private) fail with no change when the lock flag is set. Otherwise they act as the plain read and also set the flag. Plain reads leave the flag as it is.
- R10: Notify (opcode 7) from port i on an uncached block gives ok, sets the code to 11, sets the presence to only bit i and clears the lock flag. On a notify block it gives ok and adds bit i. On a shared block it is aborted with rsp_irq holding the other present ports.
- R11: On a notify block, any writeback (3, 4, 10, 11) gives ok, sets the lock flag and interrupts every present port when the flag is clear. It is aborted with no change when the flag is set. Read-shared (0) gives ok and clears the flag. Opcodes 1, 2, 8 and 9 are aborted. Lock and unlock fail. None of these changes the presence mask.
- R12: A directory write (opcode 13) stores op_wdata verbatim whatever the port. A directory read (opcode 12) leaves the entry unchanged. Both give ok with no interrupt.
- R13: Opcodes 14 and 15, and any opcode from 0 to 11 with a port number of 13 or more, fail with no interrupt and no change to the entry.
- R14: While rsp_valid is high, exactly one of rsp_ok, rsp_abort and rsp_fail is high, and rsp_entry shows the entry as left by the operation. While rsp_valid is low, all of these and rsp_irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented |
| op_ready | output | 1 | Engine can take an operation this cycle |
| op_code | input | 4 | Operation code |
| op_port | input | 4 | Requesting port number |
| op_idx | input | IDX_W | Block index into the directory |
| op_wdata | input | 16 | Entry value for a directory write |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_abort | output | 1 | Operation aborted, retry later |
| rsp_fail | output | 1 | Operation failed |
| rsp_irq | output | 13 | Ports to interrupt |
| rsp_entry | output | 16 | Entry after the operation |

## Verification
The hardest states to reach are those in which mailbox mode meets a lock flag that is already set. A writeback must then be refused, and a read-shared must rearm the block. Reaching these states takes a directed chain of a notify registration from two ports, a first writeback, a second writeback that must abort, a reader that clears the flag, and a final writeback that succeeds again. The same holds for a lock waiter whose presence bit must survive until an unlock interrupts it. Each chain runs back to back on a single index. After the chains, a long random mix confined to four indices keeps entries reusing each other's leftover state. The behavioural model is compared after every operation.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  localparam int NPORT   = 13;
  localparam int PORT_W  = 4;
  localparam int ENTRY_W = 16;

  typedef enum logic [1:0] {
    CC_UNDEF = 2'b00,
    CC_SHR   = 2'b01,
    CC_PRV   = 2'b10,
    CC_NTF   = 2'b11
  } cc_e;

  typedef struct packed {
    cc_e              cc;
    logic             lk;
    logic [NPORT-1:0] pres;
  } dir_entry_t;

  typedef enum logic [3:0] {
    OP_RD_SH    = 4'd0,
    OP_RD_PV    = 4'd1,
    OP_OWN      = 4'd2,
    OP_WB_KEEP  = 4'd3,
    OP_WB_DROP  = 4'd4,
    OP_LOCK     = 4'd5,
    OP_UNLOCK   = 4'd6,
    OP_NOTIFY   = 4'd7,
    OP_RD_SH_LK = 4'd8,
    OP_RD_PV_LK = 4'd9,
    OP_WB_KEEPU = 4'd10,
    OP_WB_DROPU = 4'd11,
    OP_DIR_RD   = 4'd12,
    OP_DIR_WR   = 4'd13
  } dir_op_e;

  // outcome vector ordering: {fail, abort, ok}
  localparam logic [2:0] RES_OK    = 3'b001;
  localparam logic [2:0] RES_ABORT = 3'b010;
  localparam logic [2:0] RES_FAIL  = 3'b100;

  typedef struct packed {
    dir_entry_t       nxt;
    logic [2:0]       res;
    logic [NPORT-1:0] irq;
  } dir_eval_t;

  function automatic logic [NPORT-1:0] port_mask(input logic [PORT_W-1:0] port);
    return NPORT'(1) << port;
  endfunction

  function automatic logic is_wb(input logic [3:0] op);
    return op == OP_WB_KEEP || op == OP_WB_DROP || op == OP_WB_KEEPU || op == OP_WB_DROPU;
  endfunction

  function automatic logic takes_lock(input logic [3:0] op);
    return op == OP_RD_SH_LK || op == OP_RD_PV_LK;
  endfunction

  function automatic logic wants_shared(input logic [3:0] op);
    return op == OP_RD_SH || op == OP_RD_SH_LK;
  endfunction

  function automatic dir_eval_t dir_eval(input dir_entry_t cur, input logic [3:0] op,
                                         input logic [PORT_W-1:0] port,
                                         input logic [ENTRY_W-1:0] wdata);
    dir_eval_t        r;
    logic [NPORT-1:0] m, oth;
    logic             unc, ntf, prv, own;
    r.nxt = cur;
    r.res = RES_FAIL;
    r.irq = '0;
    m   = port_mask(port);
    oth = cur.pres & ~m;
    unc = (cur.pres == '0);
    ntf = !unc && cur.cc == CC_NTF;
    prv = !unc && cur.cc == CC_PRV;
    own = prv && cur.pres == m;
    if (op == OP_DIR_RD) begin
      r.res = RES_OK;
    end else if (op == OP_DIR_WR) begin
      r.nxt = dir_entry_t'(wdata);
      r.res = RES_OK;
    end else if (op > OP_DIR_WR || port >= PORT_W'(NPORT)) begin
      r.res = RES_FAIL;
    end else if (ntf) begin
      if (op == OP_RD_SH) begin
        r.res    = RES_OK;
        r.nxt.lk = 1'b0;
      end else if (is_wb(op)) begin
        if (cur.lk) r.res = RES_ABORT;
        else begin
          r.res    = RES_OK;
          r.nxt.lk = 1'b1;
          r.irq    = cur.pres;
        end
      end else if (op == OP_NOTIFY) begin
        r.res      = RES_OK;
        r.nxt.pres = cur.pres | m;
      end else if (op == OP_LOCK || op == OP_UNLOCK) begin
        r.res = RES_FAIL;
      end else begin
        r.res = RES_ABORT;
      end
    end else begin
      case (op)
        OP_RD_SH, OP_RD_PV, OP_OWN, OP_RD_SH_LK, OP_RD_PV_LK: begin
          if (takes_lock(op) && cur.lk) begin
            r.res = RES_FAIL;
          end else if (prv && !own) begin
            r.res = RES_ABORT;
            r.irq = cur.pres;
          end else begin
            r.res = RES_OK;
            if (takes_lock(op)) r.nxt.lk = 1'b1;
            if (wants_shared(op)) begin
              if (!own) begin
                r.nxt.cc   = CC_SHR;
                r.nxt.pres = cur.pres | m;
              end
            end else begin
              r.nxt.cc   = CC_PRV;
              r.nxt.pres = m;
              r.irq      = oth;
            end
          end
        end
        OP_WB_KEEP, OP_WB_DROP, OP_WB_KEEPU, OP_WB_DROPU: begin
          if (own) begin
            r.res    = RES_OK;
            r.nxt.cc = CC_SHR;
            if (op == OP_WB_DROP || op == OP_WB_DROPU) r.nxt.pres = '0;
            if (op == OP_WB_KEEPU || op == OP_WB_DROPU) r.nxt.lk = 1'b0;
          end
        end
        OP_LOCK: begin
          if (prv && !own) begin
            r.res = RES_ABORT;
            r.irq = cur.pres;
          end else begin
            r.nxt.pres = cur.pres | m;
            if (unc) r.nxt.cc = CC_SHR;
            if (cur.lk) r.res = RES_FAIL;
            else begin
              r.res    = RES_OK;
              r.nxt.lk = 1'b1;
            end
          end
        end
        OP_UNLOCK: begin
          r.res    = RES_OK;
          r.nxt.lk = 1'b0;
          r.irq    = oth;
        end
        OP_NOTIFY: begin
          if (unc) begin
            r.res      = RES_OK;
            r.nxt.cc   = CC_NTF;
            r.nxt.pres = m;
            r.nxt.lk   = 1'b0;
          end else begin
            r.res = RES_ABORT;
            r.irq = oth;
          end
        end
        default: r.res = RES_FAIL;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/coh_dir_ram.sv
module coh_dir_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/coh_dir_seq.sv
module coh_dir_seq #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  output logic             accept,
  output logic             in_eval,
  output logic             init_we,
  output logic [IDX_W-1:0] init_addr,
  output logic             init_busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_EVAL} seq_e;
  seq_e             st;
  logic [IDX_W-1:0] cnt;

  assign op_ready  = (st == S_IDLE);
  assign accept    = op_ready && op_valid;
  assign in_eval   = (st == S_EVAL);
  assign init_we   = (st == S_INIT);
  assign init_busy = init_we;
  assign init_addr = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_INIT;
      cnt <= '0;
    end else begin
      case (st)
        S_INIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_IDLE;
        end
        S_IDLE: if (accept) st <= S_EVAL;
        S_EVAL: st <= S_IDLE;
        default: st <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/coh_dir_rule.sv
module coh_dir_rule
  import coh_dir_pkg::*;
(
  input  dir_entry_t          cur,
  input  logic [3:0]          op,
  input  logic [PORT_W-1:0]   port,
  input  logic [ENTRY_W-1:0]  wdata,
  output dir_entry_t          nxt,
  output logic [2:0]          res,
  output logic [NPORT-1:0]    irq
);
  dir_eval_t ev;

  always_comb begin
    ev  = dir_eval(cur, op, port, wdata);
    nxt = ev.nxt;
    res = ev.res;
    irq = ev.irq;
  end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [3:0]         op_code,
  input  logic [3:0]         op_port,
  input  logic [IDX_W-1:0]   op_idx,
  input  logic [15:0]        op_wdata,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_abort,
  output logic               rsp_fail,
  output logic [12:0]        rsp_irq,
  output logic [15:0]        rsp_entry
);
  logic             accept, in_eval, init_we, init_busy;
  logic [IDX_W-1:0] init_addr;

  logic [3:0]         q_code;
  logic [PORT_W-1:0]  q_port;
  logic [IDX_W-1:0]   q_idx;
  logic [ENTRY_W-1:0] q_wdata;

  logic [ENTRY_W-1:0] ram_rdata;
  logic               ram_we;
  logic [IDX_W-1:0]   ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata;

  dir_entry_t       cur_entry, nxt_entry;
  logic [2:0]       eval_res;
  logic [NPORT-1:0] eval_irq;

  coh_dir_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .accept(accept), .in_eval(in_eval), .init_we(init_we),
    .init_addr(init_addr), .init_busy(init_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_code  <= '0;
      q_port  <= '0;
      q_idx   <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_code  <= op_code;
      q_port  <= op_port;
      q_idx   <= op_idx;
      q_wdata <= op_wdata;
    end
  end

  assign ram_we    = init_we || in_eval;
  assign ram_waddr = init_we ? init_addr : q_idx;
  assign ram_wdata = init_we ? '0 : ENTRY_W'(nxt_entry);

  coh_dir_ram #(.DEPTH(DEPTH), .AW(IDX_W), .W(ENTRY_W)) u_ram (
    .clk(clk), .rd_en(accept), .rd_addr(op_idx), .rd_data(ram_rdata),
    .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata)
  );

  assign cur_entry = dir_entry_t'(ram_rdata);

  coh_dir_rule u_rule (
    .cur(cur_entry), .op(q_code), .port(q_port), .wdata(q_wdata),
    .nxt(nxt_entry), .res(eval_res), .irq(eval_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_abort <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_irq   <= '0;
      rsp_entry <= '0;
    end else if (in_eval) begin
      rsp_valid <= 1'b1;
      rsp_ok    <= eval_res[0];
      rsp_abort <= eval_res[1];
      rsp_fail  <= eval_res[2];
      rsp_irq   <= eval_irq;
      rsp_entry <= ENTRY_W'(nxt_entry);
    end else begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_abort <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_irq   <= '0;
      rsp_entry <= '0;
    end
  end
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic [3:0]  op_code,
  input logic [3:0]  op_port,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        rsp_abort,
  input logic        rsp_fail,
  input logic [12:0] rsp_irq,
  input logic        init_busy
);
  // R14
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_abort, rsp_fail}) == 1);

  // R14
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_irq == '0 && !rsp_ok && !rsp_abort && !rsp_fail));

  // R2
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (!op_ready && !rsp_valid));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> ##1 rsp_valid);

  // R13
  bad_port_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_port >= 4'd13 && op_code < 4'd12) |=> ##1 (rsp_fail && rsp_irq == '0));

  // R1
  no_accept_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |=> !rsp_valid);
endmodule

bind coh_dir_ctrl coh_dir_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .op_port(op_port), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_abort(rsp_abort), .rsp_fail(rsp_fail),
  .rsp_irq(rsp_irq), .init_busy(init_busy)
);

// File: tb/coh_dir_ctrl_tb.sv
`timescale 1ns/1ps
module coh_dir_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [3:0]       op_code = '0;
  logic [3:0]       op_port = '0;
  logic [IDX_W-1:0] op_idx = '0;
  logic [15:0]      op_wdata = '0;
  logic             rsp_valid, rsp_ok, rsp_abort, rsp_fail;
  logic [12:0]      rsp_irq;
  logic [15:0]      rsp_entry;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 1'b0;
  logic [15:0] mdl [DEPTH];

  always #2 clk = ~clk;

  coh_dir_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_port(op_port), .op_idx(op_idx), .op_wdata(op_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_abort(rsp_abort),
    .rsp_fail(rsp_fail), .rsp_irq(rsp_irq), .rsp_entry(rsp_entry)
  );

  task automatic check(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: outcome 0 ok, 1 abort, 2 fail
  function automatic void ref_step(input logic [15:0] e, input int op, input int p,
                                   input logic [15:0] wd, output logic [15:0] ne,
                                   output int res, output logic [12:0] irq);
    logic [1:0]  cc;
    bit          lk;
    logic [12:0] pm, me;
    bit          empty, mine, foreign;
    cc = e[15:14]; lk = e[13]; pm = e[12:0];
    ne = e; res = 2; irq = '0;
    if (op == 12) begin res = 0; return; end
    if (op == 13) begin ne = wd; res = 0; return; end
    if (op > 13 || p > 12) return;
    me      = 13'(1) << p;
    empty   = (pm == 0);
    mine    = !empty && cc == 2'b10 && pm == me;
    foreign = !empty && cc == 2'b10 && pm != me;
    if (!empty && cc == 2'b11) begin
      if (op == 0) begin res = 0; lk = 0; end
      else if (op == 3 || op == 4 || op == 10 || op == 11) begin
        if (lk) res = 1; else begin res = 0; lk = 1; irq = pm; end
      end
      else if (op == 7) begin res = 0; pm = pm | me; end
      else if (op == 5 || op == 6) res = 2;
      else res = 1;
    end else begin
      case (op)
        0, 1, 2, 8, 9: begin
          if ((op == 8 || op == 9) && lk) res = 2;
          else if (foreign) begin res = 1; irq = pm; end
          else begin
            res = 0;
            if (op >= 8) lk = 1;
            if (op == 0 || op == 8) begin
              if (!mine) begin cc = 2'b01; pm = pm | me; end
            end else begin
              irq = pm & ~me; cc = 2'b10; pm = me;
            end
          end
        end
        3, 4, 10, 11: begin
          if (mine) begin
            res = 0; cc = 2'b01;
            if (op == 4 || op == 11) pm = '0;
            if (op >= 10) lk = 0;
          end
        end
        5: begin
          if (foreign) begin res = 1; irq = pm; end
          else begin
            if (empty) cc = 2'b01;
            pm = pm | me;
            if (lk) res = 2; else begin res = 0; lk = 1; end
          end
        end
        6: begin res = 0; lk = 0; irq = pm & ~me; end
        7: begin
          if (empty) begin cc = 2'b11; pm = me; lk = 0; res = 0; end
          else begin res = 1; irq = pm & ~me; end
        end
        default: res = 2;
      endcase
    end
    ne = {cc, lk, pm};
  endfunction

  // issue one operation; caller is at a negedge
  task automatic do_op(input int op, input int p, input int idx, input logic [15:0] wd,
                       input string req);
    logic [15:0] ne;
    int          res;
    logic [12:0] irq;
    int          guard = 0;
    while (!op_ready && guard < 1000) begin @(negedge clk); guard++; end
    ref_step(mdl[idx], op, p, wd, ne, res, irq);
    op_valid = 1'b1; op_code = 4'(op); op_port = 4'(p); op_idx = IDX_W'(idx); op_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0;
    check(!rsp_valid && !op_ready, "R2", "busy gap", {rsp_valid, op_ready}, 0);
    @(negedge clk);
    check(rsp_valid === 1'b1, "R2", "rsp_valid", rsp_valid, 1);
    check({rsp_fail, rsp_abort, rsp_ok} === (3'b001 << res), req, "outcome",
          {rsp_fail, rsp_abort, rsp_ok}, 3'b001 << res);
    check(rsp_irq === irq, req, "irq", rsp_irq, irq);
    check(rsp_entry === ne, req, "entry", rsp_entry, ne);
    mdl[idx] = ne;
  endtask

  task automatic do_reset();
    int cnt = 0;
    op_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !op_ready, "R1", "in reset", {rsp_valid, op_ready}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    while (!op_ready && cnt < 10 * DEPTH) begin cnt++; @(negedge clk); end
    check(cnt == DEPTH, "R1", "sweep cycles", cnt, DEPTH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    do_op(13, 0, 20, 16'h7FFF, "R12");
    do_reset();
    do_op(12, 0, 20, 16'h0, "R1");
    do_op(12, 0, 63, 16'h0, "R1");

    // R3 reads on uncached / shared
    do_op(0, 0, 1, 0, "R3");
    do_op(0, 3, 1, 0, "R3");
    do_op(1, 2, 2, 0, "R3");
    // R4 upgrade on shared
    do_op(1, 5, 1, 0, "R4");
    do_op(0, 1, 3, 0, "R3");
    do_op(0, 4, 3, 0, "R3");
    do_op(2, 4, 3, 0, "R4");
    // R5 private by another port
    do_op(0, 7, 2, 0, "R5");
    do_op(5, 7, 2, 0, "R5");
    do_op(7, 7, 2, 0, "R5");
    do_op(0, 2, 2, 0, "R5");
    // R6 writebacks
    do_op(3, 9, 2, 0, "R6");
    do_op(3, 2, 2, 0, "R6");
    do_op(1, 2, 2, 0, "R4");
    do_op(4, 2, 2, 0, "R6");
    // R7 lock, R9 locking reads
    do_op(5, 1, 4, 0, "R7");
    do_op(5, 6, 4, 0, "R7");
    do_op(8, 8, 4, 0, "R9");
    do_op(0, 8, 4, 0, "R9");
    do_op(9, 11, 6, 0, "R9");
    // R8 unlock
    do_op(6, 1, 4, 0, "R8");
    do_op(10, 11, 6, 0, "R8");
    do_op(8, 8, 4, 0, "R9");
    // R10 notify registration
    do_op(7, 3, 8, 0, "R10");
    do_op(7, 10, 8, 0, "R10");
    do_op(7, 0, 1, 0, "R10");
    do_op(7, 9, 3, 0, "R10");
    do_op(0, 9, 3, 0, "R3");
    do_op(7, 2, 3, 0, "R10");
    // R11 mailbox mode
    do_op(4, 12, 8, 0, "R11");
    do_op(3, 12, 8, 0, "R11");
    do_op(1, 3, 8, 0, "R11");
    do_op(5, 3, 8, 0, "R11");
    do_op(6, 3, 8, 0, "R11");
    do_op(0, 10, 8, 0, "R11");
    do_op(11, 12, 8, 0, "R11");
    // R12 software access
    do_op(13, 15, 10, 16'hA5C3, "R12");
    do_op(12, 2, 10, 0, "R12");
    // R13 illegal requests
    do_op(0, 13, 1, 0, "R13");
    do_op(5, 15, 4, 0, "R13");
    do_op(14, 0, 1, 0, "R13");
    do_op(15, 1, 8, 0, "R13");
    do_op(12, 0, 1, 0, "R13");

    // random mix on a few indices, every response against the model (R14)
    for (int n = 0; n < 600; n++) begin
      int op  = int'($urandom_range(0, 15));
      int p   = int'($urandom_range(0, 14));
      int idx = int'($urandom_range(32, 35));
      if (op == 13 && ($urandom_range(0, 3) != 0)) op = 0;
      do_op(op, p, idx, 16'($urandom), "R14");
    end

    @(negedge clk);
    check(!rsp_valid && rsp_irq == 0, "R14", "quiet", {rsp_valid, rsp_irq}, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule